// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Decoder with Identifier Readout

This block models the device-side control logic of a byte-wide one-time-programmable memory. Each cycle it takes the chip-select and output-gate pins, the program strobe, the address, and two flags that stand in for analog conditions. One flag says a high voltage is present on address bit 9. The other says the programming supply is raised. From these it decodes one of eight device modes, which it reports on a 3-bit status output.

The mode sets what the data bus carries. In a driving mode the bus returns the addressed byte of an internal storage array, or a fixed identifier byte. In every other mode it sits at high impedance: `dq_oe` is low and `dq_out` reads zero. While chip select is inactive, the output gate has no effect. In program mode the byte on the bus is merged into the addressed location on each rising clock edge. The merge is a bitwise AND, so a bit can only go from 1 to 0. Several devices can share every line except chip select and program only the selected one.

The storage depth is a parameter. The address is reduced modulo that depth. Reset fills the storage with ones.

Top module: `otp_mode_core`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and no identifier request, `mode_o`=0 and `dq_oe`=1. `dq_out` carries the stored byte at the addressed location.
- R2: With `ce_n`=0, `oe_n`=1 and `pgm_n`=1 (supply raised or not), `mode_o`=1. `dq_oe`=0 and `dq_out`=0x00.
- R3: With `ce_n`=1 and `vpp_hi`=0, `dq_oe`=0 whatever `oe_n` is. `mode_o` is 2 when `cmos_sel`=0 and 3 when `cmos_sel`=1.
- R4: With `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0, `mode_o`=4 and `dq_oe`=0. On each rising clock edge the addressed byte becomes its old value AND `dq_in`.
- R5: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=0, `mode_o`=5 and `dq_oe`=1. `dq_out` carries the stored byte.
- R6: With `vpp_hi`=1 and `ce_n`=1, `mode_o`=6 and `dq_oe`=0. No stored byte changes, even with `pgm_n`=0.
- R7: An identifier request is `vpp_hi`=0, `ce_n`=0, `oe_n`=0 and `a9_hv`=1, with every address bit other than bits 0 and 9 at zero. It gives `mode_o`=7 and `dq_out`=0xC2 when `addr[0]`=0 or 0xCA when `addr[0]`=1. If any other address bit is set, the request becomes a read (R1).
- R8: Programming only clears bits. A second program of the same location with new data leaves the AND of both data bytes with the earlier contents. Programming with 0xFF changes nothing.
- R9: After reset every stored byte reads 0xFF.
- R10: The location used is `addr` modulo `DEPTH`, for both reading and programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; fills storage with ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| cmos_sel | input | 1 | Chip select is at rail level (selects the deeper standby) |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data from the bus, used in program mode |
| dq_out | output | 8 | Data to the bus; zero when not driving |
| dq_oe | output | 1 | Bus driver enable |
| mode_o | output | 3 | Decoded mode, 0 to 7 as listed in the requirements |

## Verification
The decoder is exercised with every combination that separates neighbouring modes. Chip select is tried with the output gate both low and high. The supply flag is raised and lowered under the same pins, and the strobe is set both ways while the supply is raised. These pairs show whether standby overrides the output gate and whether a raised supply moves the device into program, verify or inhibit. The identifier path is tried with `addr[0]` low and high, with `addr[9]` set, and with an unrelated address bit set, which separates a true identifier request from a read. The storage is programmed with overlapping and all-ones data, and at an address above the depth. These patterns show whether a write is an AND, whether it takes effect in program mode only, and whether the address wraps.

// File: rtl/otp_mode_pkg.sv
package otp_mode_pkg;

  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_OUT_OFF   = 3'd1,
    M_STBY_TTL  = 3'd2,
    M_STBY_CMOS = 3'd3,
    M_PROGRAM   = 3'd4,
    M_VERIFY    = 3'd5,
    M_INHIBIT   = 3'd6,
    M_IDENT     = 3'd7
  } otp_mode_e;

  // Modes in which the device drives the bus
  function automatic logic mode_drives(otp_mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
  endfunction

  // Result of a program pulse: bits can only be cleared
  function automatic logic [7:0] burn_byte(logic [7:0] old_v, logic [7:0] new_v);
    return old_v & new_v;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_mode_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              cmos_sel,
  input  logic [ADDR_W-1:0] addr,
  output otp_mode_e         mode
);

  localparam logic [ADDR_W-1:0] IdentFree = ADDR_W'((1 << 9) | 1);

  // True when only bits 0 and 9 may be non-zero
  function automatic logic ident_addr_ok(logic [ADDR_W-1:0] a);
    return (a & ~IdentFree) == '0;
  endfunction

  logic ident_req;
  assign ident_req = a9_hv && ident_addr_ok(addr);

  always_comb begin
    if (ce_n) begin
      if (vpp_hi)        mode = M_INHIBIT;
      else if (cmos_sel) mode = M_STBY_CMOS;
      else               mode = M_STBY_TTL;
    end else if (vpp_hi) begin
      if (!oe_n)         mode = M_VERIFY;
      else if (!pgm_n)   mode = M_PROGRAM;
      else               mode = M_OUT_OFF;
    end else begin
      if (oe_n)           mode = M_OUT_OFF;
      else if (ident_req) mode = M_IDENT;
      else                mode = M_READ;
    end
  end

endmodule

// File: rtl/otp_sig_rom.sv
module otp_sig_rom #(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hCA
) (
  input  logic       sel_dev,
  output logic [7:0] code
);

  assign code = sel_dev ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_mode_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data
);

  logic [7:0]       cells [DEPTH];
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       wr_old;
  logic [7:0]       last_word;

  assign rd_data   = cells[idx];
  assign wr_old    = cells[idx];
  assign last_word = cells[last_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      last_idx <= '0;
    end else begin
      last_idx <= idx;
      if (wr_en) cells[idx] <= burn_byte(wr_old, wr_data);
    end
  end

  // R4
  // R8
  burn_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (last_word == ($past(wr_old) & $past(wr_data))));

  // R8
  no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((last_word & ~$past(wr_old)) == 8'h00));

endmodule

// File: rtl/otp_mode_core.sv
module otp_mode_core
  import otp_mode_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter int         DEPTH    = 16,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hCA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              cmos_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [2:0]        mode_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Location = address modulo depth
  function automatic logic [IDX_W-1:0] cell_of(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a % ADDR_W'(DEPTH);
    return r[IDX_W-1:0];
  endfunction

  otp_mode_e        mode;
  logic [IDX_W-1:0] cell_idx;
  logic             write_pulse;
  logic [7:0]       cell_byte;
  logic [7:0]       ident_byte;
  logic             bus_drive;

  otp_mode_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .cmos_sel(cmos_sel), .addr(addr), .mode(mode)
  );

  otp_sig_rom #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_sig (
    .sel_dev(addr[0]), .code(ident_byte)
  );

  assign cell_idx    = cell_of(addr);
  assign write_pulse = (mode == M_PROGRAM);

  otp_cell_array #(.DEPTH(DEPTH)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(write_pulse), .idx(cell_idx),
    .wr_data(dq_in), .rd_data(cell_byte)
  );

  assign bus_drive = mode_drives(mode);
  assign dq_oe     = bus_drive;
  assign mode_o    = mode;

  always_comb begin
    if (!bus_drive)            dq_out = 8'h00;
    else if (mode == M_IDENT)  dq_out = ident_byte;
    else                       dq_out = cell_byte;
  end

  // R3
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> (!dq_oe && dq_out == 8'h00));

  // R2
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R6
  inhibit_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_hi) |-> (!write_pulse && !dq_oe));

  // R7
  ident_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd7) |-> (dq_out == (addr[0] ? DEV_CODE : MFR_CODE)));

  // R4
  prog_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_pulse |-> (vpp_hi && !ce_n && oe_n && !pgm_n));

endmodule

// File: tb/otp_mode_core_bench.sv
module otp_mode_core_bench;

  localparam int ADDR_W = 17;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic              vpp_hi = 1'b0, a9_hv = 1'b0, cmos_sel = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dq_in = 8'hFF;
  logic [7:0]        dq_out;
  logic              dq_oe;
  logic [2:0]        mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_mode_core #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_otp_mode_core (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .cmos_sel(cmos_sel), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .mode_o(mode_o)
  );

  // Drive pins just after a falling edge, then settle before sampling
  task automatic put(input logic c, input logic o, input logic p, input logic v,
                     input logic a9, input logic cm, input int ad, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = a9; cmos_sel = cm;
    addr = ADDR_W'(ad); dq_in = d;
    #2;
  endtask

  task automatic expect_bus(input string req, input logic [2:0] m,
                            input logic oe, input logic [7:0] v);
    checks++;
    if (mode_o !== m || dq_oe !== oe || dq_out !== v) begin
      failures++;
      $display("FAIL %s: mode=%0d oe=%0b data=%h expected mode=%0d oe=%0b data=%h",
               req, mode_o, dq_oe, dq_out, m, oe, v);
    end
  endtask

  task automatic read_at(input string req, input int ad, input logic [7:0] v);
    put(0, 0, 1, 0, 0, 0, ad, 8'hFF);
    expect_bus(req, 3'd0, 1'b1, v);
  endtask

  task automatic t_reset;
    put(1, 0, 1, 0, 0, 0, 0, 8'h00);
    expect_bus("R3 ttl standby after reset", 3'd2, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH; i++) read_at("R9 erased byte", i, 8'hFF);
  endtask

  task automatic t_standby;
    put(1, 0, 0, 0, 0, 1, 3, 8'h00);
    expect_bus("R3 cmos standby oe low", 3'd3, 1'b0, 8'h00);
    put(1, 1, 1, 0, 0, 0, 3, 8'h00);
    expect_bus("R3 ttl standby oe high", 3'd2, 1'b0, 8'h00);
    put(1, 0, 1, 0, 1, 0, 0, 8'h00);
    expect_bus("R3 standby over ident", 3'd2, 1'b0, 8'h00);
  endtask

  task automatic t_program;
    put(0, 1, 0, 1, 0, 0, 5, 8'h3C);
    expect_bus("R4 program mode hi-z", 3'd4, 1'b0, 8'h00);
    put(0, 0, 1, 1, 0, 0, 5, 8'hFF);
    expect_bus("R5 verify after program", 3'd5, 1'b1, 8'h3C);
    read_at("R1 read programmed byte", 5, 8'h3C);
    read_at("R1 neighbour untouched", 6, 8'hFF);
    put(0, 1, 1, 0, 0, 0, 5, 8'h00);
    expect_bus("R2 output off", 3'd1, 1'b0, 8'h00);
    put(0, 1, 1, 1, 0, 0, 5, 8'h00);
    expect_bus("R2 output off supply high", 3'd1, 1'b0, 8'h00);
    read_at("R2 no write when strobe high", 5, 8'h3C);
  endtask

  task automatic t_and;
    put(0, 1, 0, 1, 0, 0, 5, 8'hF0);
    put(0, 0, 1, 1, 0, 0, 5, 8'hFF);
    expect_bus("R8 second program ANDs", 3'd5, 1'b1, 8'h30);
    put(0, 1, 0, 1, 0, 0, 5, 8'hFF);
    put(0, 0, 0, 1, 0, 0, 5, 8'hFF);
    expect_bus("R8 all-ones program no change", 3'd5, 1'b1, 8'h30);
  endtask

  task automatic t_inhibit;
    put(1, 1, 0, 1, 0, 0, 5, 8'h00);
    expect_bus("R6 inhibit hi-z", 3'd6, 1'b0, 8'h00);
    put(1, 0, 0, 1, 0, 0, 5, 8'h00);
    expect_bus("R6 inhibit oe low", 3'd6, 1'b0, 8'h00);
    read_at("R6 inhibited byte kept", 5, 8'h30);
  endtask

  task automatic t_ident;
    put(0, 0, 1, 0, 1, 0, 0, 8'h00);
    expect_bus("R7 manufacturer code", 3'd7, 1'b1, 8'hC2);
    put(0, 0, 1, 0, 1, 0, 1, 8'h00);
    expect_bus("R7 device code", 3'd7, 1'b1, 8'hCA);
    put(0, 0, 1, 0, 1, 0, 32'h201, 8'h00);
    expect_bus("R7 bit9 allowed", 3'd7, 1'b1, 8'hCA);
    put(0, 0, 1, 0, 1, 0, 5, 8'h00);
    expect_bus("R7 other bit falls to read", 3'd0, 1'b1, 8'h30);
    put(0, 1, 1, 0, 1, 0, 0, 8'h00);
    expect_bus("R7 ident gated by oe", 3'd1, 1'b0, 8'h00);
  endtask

  task automatic t_wrap;
    put(0, 1, 0, 1, 0, 0, DEPTH + 7, 8'h81);
    read_at("R10 wrapped write", 7, 8'h81);
    read_at("R10 wrapped read", 3 * DEPTH + 5, 8'h30);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_standby;
    t_program;
    t_and;
    t_inhibit;
    t_ident;
    t_wrap;
    finish_run;
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run;
  end

endmodule